// File: doc/BRIEF.md
# Programmable Interrupt Countdown Timer

This block is the countdown timer that sits beside one processor's interrupt controller. Software programs it through a word-indexed register bus. Three registers are writable:

- a start value, which loads the counter;
- a prescaler code, which sets the decrement rate as a power-of-two fraction of the input clock;
- a vector entry, which holds the interrupt vector, a mask bit and a one-shot/periodic mode bit.

A fourth, read-only register reports the live count.

When the count runs past zero, the block emits a one-cycle request that carries the 8-bit vector from the entry. The mask suppresses that request. Prioritisation and delivery of the request happen elsewhere.

The counter is a three-state machine built on `cnt_state_e`:

- `ST_IDLE` holds a zero count. The block is here after reset and after a zero start value is loaded.
- `ST_COUNT` counts down at the prescaled rate.
- `ST_EXPIRED` is where a one-shot run parks once it has fired.

The transitions are:

- **load**: from any state, a start-value write enters `ST_COUNT`, or `ST_IDLE` when the value is zero.
- **decrement**: `ST_COUNT` to `ST_COUNT` on a prescaled tick with a nonzero count.
- **reload**: `ST_COUNT` to `ST_COUNT` on a tick at zero in periodic mode.
- **finish**: `ST_COUNT` to `ST_EXPIRED` on a tick at zero in one-shot mode.

Top module: `cdtimer_top`

## Requirements
- R1: After reset, the registers read as follows: vector entry (index 0x32) 0x0001_0000, start value (index 0x38) 0, live count (index 0x39) 0, prescaler code (index 0x3E) 0. No request is raised.
- R2: The prescaler code keeps only write bits 3, 1 and 0. Every other bit reads back as zero, so writing 0xFFFF_FFFF reads back as 0x0000_000B.
- R3: With code c, the count decrements once every 2^e input clocks, where e = ({c[3],c[1],c[0]} + 1) mod 8. Code 0xB divides by 1, code 0x0 by 2, and code 0x8 by 32.
- R4: A start-value write loads the count on that same clock edge and restarts the prescaler. The live count then reads start minus the elapsed prescaled ticks.
- R5: In one-shot mode (entry bit 17 = 0), the request fires exactly once, on the tick after the count reaches zero (start+1 ticks after the load). The count then stays at zero.
- R6: In periodic mode (entry bit 17 = 1), the count reloads the start value on the tick that finds it at zero. A request fires every start+1 ticks.
- R7: A start value of zero never produces a request, in either mode.
- R8: With entry bit 16 = 1 (masked), no request is raised, but the count still runs and still reads back.
- R9: A request is a single-cycle `irq_valid` pulse, with `irq_vector` equal to entry bits 7:0.
- R10: Writes to the live-count index 0x39 have no effect on the count.
- R11: Rewriting the vector entry while the count runs changes the mode and mask from the next tick and does not reload the count.
- R12: The vector entry keeps only bits 17, 16 and 7:0. Writing 0xFFFF_FFFF reads back as 0x0003_00FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 8 | Word index for the write and the read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_valid | output | 1 | One-cycle expiry request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
The hardest case to reach from the ports is an entry rewrite that lands in the middle of a periodic run. The rewrite has to fall exactly between two ticks, and the bench must then tell "mode switched without a reload" apart from "counter restarted". The stimulus uses a divide-by-1 prescaler and a start value of 3. It watches the first periodic request, then rewrites the entry to one-shot on the edge that brings the count to zero. The single following request must appear on the very next tick, with no later request. A long divide-by-32 run and a write to the read-only count index cover the prescaler decode and the ignored write.

// File: rtl/cdtimer_pkg.sv
package cdtimer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COUNT,
        ST_EXPIRED
    } cnt_state_e;

    localparam logic [7:0] IDX_ENTRY = 8'h32;
    localparam logic [7:0] IDX_START = 8'h38;
    localparam logic [7:0] IDX_LIVE  = 8'h39;
    localparam logic [7:0] IDX_PSC   = 8'h3E;

    localparam int ENT_MODE_BIT = 17;
    localparam int ENT_MASK_BIT = 16;
    localparam int EXP_W        = 3;

endpackage

// File: rtl/cdtimer_prescaler.sv
module cdtimer_prescaler
    import cdtimer_pkg::*;
#(
    parameter int EW = EXP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [EW-1:0] exponent,
    output logic          tick
);
    localparam int PW = (1 << EW) - 1;

    logic [PW-1:0] div_cnt;
    logic [PW-1:0] sel_mask;

    // A mask of "exponent" low ones; a tick fires when those bits of the counter are all set.
    for (genvar i = 0; i < PW; i++) begin : g_mask
        assign sel_mask[i] = (exponent > EW'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (restart) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    assign tick = ((div_cnt & sel_mask) == sel_mask);

endmodule

// File: rtl/cdtimer_regs.sv
module cdtimer_regs
    import cdtimer_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32,
    parameter int CW = 32,
    parameter int VW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic [CW-1:0]    live_count,
    output logic [DW-1:0]    rdata,
    output logic [CW-1:0]    start_q,
    output logic             load,
    output logic [EXP_W-1:0] exponent,
    output logic             periodic,
    output logic             masked,
    output logic [VW-1:0]    vector
);
    logic [3:0]    psc_q;
    logic [DW-1:0] entry_word;

    assign load = wr && (addr == AW'(IDX_START));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q  <= '0;
            psc_q    <= '0;
            periodic <= 1'b0;
            masked   <= 1'b1;
            vector   <= '0;
        end else if (wr) begin
            unique case (addr)
                AW'(IDX_START): start_q <= wdata[CW-1:0];
                AW'(IDX_PSC):   psc_q   <= wdata[3:0] & 4'hB;
                AW'(IDX_ENTRY): begin
                    periodic <= wdata[ENT_MODE_BIT];
                    masked   <= wdata[ENT_MASK_BIT];
                    vector   <= wdata[VW-1:0];
                end
                default: ;
            endcase
        end
    end

    assign exponent = {psc_q[3], psc_q[1:0]} + 3'd1;

    always_comb begin
        entry_word               = '0;
        entry_word[ENT_MODE_BIT] = periodic;
        entry_word[ENT_MASK_BIT] = masked;
        entry_word[VW-1:0]       = vector;
    end

    always_comb begin
        unique case (addr)
            AW'(IDX_ENTRY): rdata = entry_word;
            AW'(IDX_START): rdata = DW'(start_q);
            AW'(IDX_LIVE):  rdata = DW'(live_count);
            AW'(IDX_PSC):   rdata = DW'(psc_q);
            default:        rdata = '0;
        endcase
    end

endmodule

// File: rtl/cdtimer_counter.sv
module cdtimer_counter
    import cdtimer_pkg::*;
#(
    parameter int CW = 32,
    parameter int VW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic [CW-1:0] reload_val,
    input  logic          tick,
    input  logic          periodic,
    input  logic          masked,
    input  logic [VW-1:0] vector,
    output logic [CW-1:0] count,
    output cnt_state_e    state,
    output logic          irq_valid,
    output logic [VW-1:0] irq_vector
);
    cnt_state_e    st_d;
    logic [CW-1:0] cnt_d;
    logic          fire;

    always_comb begin
        st_d  = state;
        cnt_d = count;
        fire  = 1'b0;
        if (load) begin
            cnt_d = load_val;
            st_d  = (load_val == '0) ? ST_IDLE : ST_COUNT;
        end else begin
            unique case (state)
                ST_IDLE, ST_EXPIRED: ;
                ST_COUNT: begin
                    if (tick) begin
                        if (count == '0) begin
                            fire = 1'b1;
                            if (periodic) begin
                                cnt_d = reload_val;
                            end else begin
                                st_d = ST_EXPIRED;
                            end
                        end else begin
                            cnt_d = count - 1'b1;
                        end
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // State register and count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            count <= '0;
        end else begin
            state <= st_d;
            count <= cnt_d;
        end
    end

    // Registered request outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_valid  <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq_valid  <= fire && !masked;
            irq_vector <= (fire && !masked) ? vector : '0;
        end
    end

endmodule

// File: rtl/cdtimer_top.sv
module cdtimer_top
    import cdtimer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_valid,
    output logic [VEC_W-1:0]  irq_vector
);
    localparam int CNT_W = DATA_W;

    logic [CNT_W-1:0] start_q;
    logic [CNT_W-1:0] live_count;
    logic             load;
    logic             tick;
    logic [EXP_W-1:0] exponent;
    logic             periodic;
    logic             masked;
    logic [VEC_W-1:0] vector;
    cnt_state_e       state;

    cdtimer_regs #(
        .AW(ADDR_W), .DW(DATA_W), .CW(CNT_W), .VW(VEC_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .live_count (live_count),
        .rdata      (reg_rdata),
        .start_q    (start_q),
        .load       (load),
        .exponent   (exponent),
        .periodic   (periodic),
        .masked     (masked),
        .vector     (vector)
    );

    cdtimer_prescaler #(.EW(EXP_W)) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (load),
        .exponent (exponent),
        .tick     (tick)
    );

    cdtimer_counter #(.CW(CNT_W), .VW(VEC_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_val   (reg_wdata[CNT_W-1:0]),
        .reload_val (start_q),
        .tick       (tick),
        .periodic   (periodic),
        .masked     (masked),
        .vector     (vector),
        .count      (live_count),
        .state      (state),
        .irq_valid  (irq_valid),
        .irq_vector (irq_vector)
    );

endmodule

// File: rtl/cdtimer_chk.sv
module cdtimer_chk
    import cdtimer_pkg::*;
#(
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          load,
    input logic [CW-1:0] count,
    input cnt_state_e    state,
    input logic          masked,
    input logic          irq_valid
);
    // R9
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> !irq_valid);

    // R5
    fire_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> ($past(count) == '0));

    // R8
    mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !$past(masked));

    // R3
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(count));

    // R4
    decrement_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && state == ST_COUNT && count != '0) |=> (count == $past(count) - 1'b1));

endmodule

bind cdtimer_top cdtimer_chk #(.CW(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .load      (load),
    .count     (live_count),
    .state     (state),
    .masked    (masked),
    .irq_valid (irq_valid)
);

// File: tb/cdtimer_top_tb.sv
module cdtimer_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cdtimer_top u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_valid  (irq_valid),
        .irq_vector (irq_vector)
    );

    localparam logic [7:0] A_ENT = 8'h32, A_START = 8'h38, A_LIVE = 8'h39, A_PSC = 8'h3E;

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = A_LIVE;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = A_LIVE;
    endtask

    // Watch n negedges after the current one; k=1 is the negedge after the next rising edge.
    task automatic watch(input int n, input int samp_k, output int first, output int cnt,
                         output int vec, output logic [31:0] cur_at);
        first = 0; cnt = 0; vec = -1; cur_at = 32'hDEAD_BEEF;
        reg_addr = A_LIVE;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            #1;
            if (irq_valid) begin
                cnt++;
                if (first == 0) begin
                    first = k;
                    vec = int'(irq_vector);
                end
            end
            if (k == samp_k) cur_at = reg_rdata;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_ENT, v);   check("R1 entry", v, 32'h0001_0000);
        rd(A_START, v); check("R1 start", v, 0);
        rd(A_LIVE, v);  check("R1 live", v, 0);
        rd(A_PSC, v);   check("R1 psc", v, 0);
        check("R1 irq", irq_valid, 0);
    endtask

    task automatic t_fields();
        logic [31:0] v;
        wr(A_PSC, 32'hFFFF_FFFF); rd(A_PSC, v); check("R2 psc bits", v, 32'h0000_000B);
        wr(A_ENT, 32'hFFFF_FFFF); rd(A_ENT, v); check("R12 entry bits", v, 32'h0003_00FF);
        wr(A_ENT, 32'h0001_0000);
    endtask

    task automatic t_oneshot();
        int f, c, vec; logic [31:0] cur;
        wr(A_ENT, 32'h0000_0041);
        wr(A_PSC, 32'h0000_000B);
        wr(A_START, 5);
        watch(20, 2, f, c, vec, cur);
        check("R4 live after 2 ticks", cur, 3);
        check("R5 one-shot first", f, 6);
        check("R5 one-shot count", c, 1);
        check("R9 vector", vec, 32'h41);
        rd(A_LIVE, cur); check("R5 stays zero", cur, 0);
    endtask

    task automatic t_divide();
        int f, c, vec; logic [31:0] cur;
        wr(A_PSC, 32'h0000_0000);
        wr(A_START, 3);
        watch(12, 5, f, c, vec, cur);
        check("R3 div2 live", cur, 1);
        check("R3 div2 fire", f, 8);
        wr(A_PSC, 32'h0000_0008);
        wr(A_START, 1);
        watch(70, 40, f, c, vec, cur);
        check("R3 div32 live", cur, 0);
        check("R3 div32 fire", f, 64);
        check("R3 div32 count", c, 1);
    endtask

    task automatic t_livewrite();
        int f, c, vec; logic [31:0] cur;
        wr(A_PSC, 32'h0000_000B);
        wr(A_START, 10);
        wr(A_LIVE, 32'h0000_1234);
        watch(14, 3, f, c, vec, cur);
        check("R10 live ignores write", cur, 5);
        check("R10 fire time", f, 9);
    endtask

    task automatic t_mask();
        int f, c, vec; logic [31:0] cur;
        wr(A_ENT, 32'h0001_0041);
        wr(A_START, 3);
        watch(12, 2, f, c, vec, cur);
        check("R8 masked runs", cur, 1);
        check("R8 masked no irq", c, 0);
    endtask

    task automatic t_periodic();
        int f, c, vec; logic [31:0] cur;
        wr(A_ENT, 32'h0002_0077);
        wr(A_START, 4);
        watch(26, 7, f, c, vec, cur);
        check("R6 periodic first", f, 5);
        check("R6 periodic count", c, 5);
        check("R6 reload value", cur, 2);
        check("R9 periodic vector", vec, 32'h77);
    endtask

    task automatic t_modechange();
        int f, c, vec; logic [31:0] cur;
        wr(A_ENT, 32'h0002_0022);
        wr(A_START, 3);
        watch(5, 5, f, c, vec, cur);
        check("R11 first periodic", f, 4);
        wr(A_ENT, 32'h0000_0022);
        rd(A_LIVE, cur); check("R11 no reload", cur, 0);
        watch(12, 12, f, c, vec, cur);
        check("R11 next tick fires", f, 1);
        check("R11 one-shot afterwards", c, 1);
    endtask

    task automatic t_zero();
        int f, c, vec; logic [31:0] cur;
        wr(A_ENT, 32'h0002_0011);
        wr(A_START, 0);
        watch(40, 20, f, c, vec, cur);
        check("R7 periodic zero", c, 0);
        check("R7 live zero", cur, 0);
        wr(A_ENT, 32'h0000_0011);
        wr(A_START, 0);
        watch(20, 20, f, c, vec, cur);
        check("R7 one-shot zero", c, 0);
    endtask

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_oneshot();
        t_divide();
        t_livewrite();
        t_mask();
        t_periodic();
        t_modechange();
        t_zero();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule